// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Access Permissions

This block holds a small, fully associative set of mappings from virtual page numbers to physical frame numbers. Each mapping belongs to one process, named by its process id, so mappings of several tasks can sit side by side and nothing has to be flushed on a task switch. On every access the virtual page number and the current process id are compared against all entries in the same cycle. The result is one of three outcomes:

- a translated physical address, made of the matched frame number and the untouched 12-bit page offset;
- a miss fault, which software services by walking its page tables;
- a protection fault, when the entry lacks the needed read or write right.

Each entry keeps a touched bit and a dirty bit. Replacement software uses the touched bit as an approximate recency marker. The dirty bit tells software whether the page must be written back. A command port fills, invalidates and clears the touched bits of entries. It acts only when the requester is privileged. A request from user mode raises a privilege fault instead and changes nothing. A fill goes to a victim entry that the block picks by itself. Software reads the status bits of any entry before it evicts that entry.

Top module: `pid_tlb`

## Requirements
- R1: With `lookupValid` high and no valid entry whose page number and process id both equal the request, `missFault` is 1 and `hit`, `protFault` are 0 in the same cycle.
- R2: On a permitted match, `hit` is 1 and `physAddr` equals {matched frame, `lookupVaddr[11:0]`} in the same cycle; whenever `hit` is 0, `physAddr` is 0.
- R3: An entry with the right page number but a different process id does not match.
- R4: Permission bits: `cmdPermRd` grants reads and `cmdPermWr` grants writes (`lookupIsWrite` = 1 means write). A match lacking the needed right gives `protFault` = 1 and `hit` = 0, and it sets no status bit. At most one of `hit`, `missFault` and `protFault` is high.
- R5: A permitted hit sets the entry's touched bit from the next cycle on; a permitted write hit also sets its dirty bit.
- R6: Commands use `cmdOp` = 1 fill, 2 invalidate all, 3 invalidate by `cmdPid`, 4 clear all touched bits, 0 none. Codes 5 to 7 are ignored. A command with `cmdPriv` = 0 drives `privFault` high in the same cycle and leaves all entry state unchanged.
- R7: `victimIdx` is the lowest-index invalid entry, else the lowest-index entry with its touched bit clear, else 0. A fill writes there and leaves the entry valid with its touched and dirty bits clear.
- R8: Invalidate-all clears every valid bit in one cycle. Invalidate-by-process clears only the entries whose id equals `cmdPid`.
- R9: Clear-touched resets every touched bit in one cycle. Within a cycle, command effects override the status updates of a hit.
- R10: `statValid`, `statTouched` and `statDirty` show the bits of the entry selected by `statIdx`, combinationally.
- R11: After reset, every entry is invalid with its touched and dirty bits clear, and `victimIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Access request present |
| lookupIsWrite | input | 1 | Access is a write |
| lookupVaddr | input | 32 | Virtual address |
| curPid | input | 8 | Process id of the access |
| hit | output | 1 | Permitted translation found |
| missFault | output | 1 | No matching entry |
| protFault | output | 1 | Match lacks the needed right |
| physAddr | output | 32 | Translated address, 0 unless hit |
| cmdValid | input | 1 | Command request present |
| cmdOp | input | 3 | Command code |
| cmdPriv | input | 1 | Requester is in privileged mode |
| cmdVpn | input | 20 | Page number for fill |
| cmdPid | input | 8 | Process id for fill or invalidate-by-process |
| cmdFrame | input | 20 | Frame number for fill |
| cmdPermRd | input | 1 | Read right for fill |
| cmdPermWr | input | 1 | Write right for fill |
| privFault | output | 1 | Command refused, user mode |
| victimIdx | output | 4 | Entry the next fill will use |
| statIdx | input | 4 | Entry selected for status readback |
| statValid | output | 1 | Valid bit of selected entry |
| statTouched | output | 1 | Touched bit of selected entry |
| statDirty | output | 1 | Dirty bit of selected entry |

## Verification
Some properties are checked on every cycle. The three lookup outcomes are mutually exclusive. The page offset passes straight through on a hit. The touched and dirty bits are set in the cycle after a hit when no command competes. Valid bits stay frozen when no strobe is raised, and a user-mode command produces no strobe. A free victim is never a valid entry, and a clear-touched command empties the touched bits. Other behaviour needs the bench's scenarios. These cover the full victim priority over a filled and then partly touched array, process-id separation between tasks that share a page number, the exact frame returned, and the selective effect of invalidate-by-process on the entries of other tasks.

// File: rtl/pid_tlb_pkg.sv
package pid_tlb_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_FILL      = 3'd1,
    OP_INV_ALL   = 3'd2,
    OP_INV_PID   = 3'd3,
    OP_CLR_TOUCH = 3'd4
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fill;
    logic invAll;
    logic invPid;
    logic clrTouched;
  } strobe_t;

endpackage

// File: rtl/pid_tlb_ctrl.sv
module pid_tlb_ctrl
  import pid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic               cmdPriv,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] touchedVec,
  output strobe_t            strb,
  output logic [IDX_W-1:0]   fillIdx,
  output logic [IDX_W-1:0]   victimIdx,
  output logic               privFault
);

  logic       knownOp;
  logic       allowed;
  cmdOp_e     opCode;

  logic             freeFound, coldFound;
  logic [IDX_W-1:0] freeIdx, coldIdx;

  always_comb begin
    opCode  = cmdOp_e'(cmdOp);
    knownOp = 1'b0;
    case (opCode)
      OP_FILL, OP_INV_ALL, OP_INV_PID, OP_CLR_TOUCH: knownOp = 1'b1;
      default:                                       knownOp = 1'b0;
    endcase
  end

  assign allowed   = cmdValid && knownOp && cmdPriv;
  assign privFault = cmdValid && knownOp && !cmdPriv;

  always_comb begin
    strb            = '0;
    strb.fill       = allowed && (opCode == OP_FILL);
    strb.invAll     = allowed && (opCode == OP_INV_ALL);
    strb.invPid     = allowed && (opCode == OP_INV_PID);
    strb.clrTouched = allowed && (opCode == OP_CLR_TOUCH);
  end

  // victim search: scan downward so the lowest index wins
  always_comb begin
    freeFound = 1'b0;
    coldFound = 1'b0;
    freeIdx   = '0;
    coldIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
      if (!touchedVec[i]) begin
        coldFound = 1'b1;
        coldIdx   = IDX_W'(i);
      end
    end
  end

  assign victimIdx = freeFound ? freeIdx : (coldFound ? coldIdx : '0);
  assign fillIdx   = victimIdx;

  AST_USER_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdPriv) |-> (strb == '0)); // R6

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (!(&validVec)) |-> !validVec[victimIdx]); // R7

endmodule

// File: rtl/pid_tlb_dpath.sv
module pid_tlb_dpath
  import pid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int PID_W   = 8,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               lkIsWrite,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [OFF_W-1:0]   lkOff,
  input  logic [PID_W-1:0]   lkPid,
  output logic               hit,
  output logic               missFault,
  output logic               protFault,
  output logic [FRAME_W+OFF_W-1:0] physAddr,
  input  strobe_t            strb,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VPN_W-1:0]   cmdVpn,
  input  logic [PID_W-1:0]   cmdPid,
  input  logic [FRAME_W-1:0] cmdFrame,
  input  logic               cmdPermRd,
  input  logic               cmdPermWr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] touchedVec,
  input  logic [IDX_W-1:0]   statIdx,
  output logic               statValid,
  output logic               statTouched,
  output logic               statDirty
);

  logic [ENTRIES-1:0] validQ, touchedQ, dirtyQ, rdQ, wrQ;
  logic [VPN_W-1:0]   vpnQ   [ENTRIES];
  logic [PID_W-1:0]   pidQ   [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];

  logic [ENTRIES-1:0] matchVec;
  logic               anyMatch;
  logic [IDX_W-1:0]   hitIdx;
  logic               permOk;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (vpnQ[g] == lkVpn) && (pidQ[g] == lkPid);
  end

  always_comb begin
    anyMatch = 1'b0;
    hitIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  assign permOk    = lkIsWrite ? wrQ[hitIdx] : rdQ[hitIdx];
  assign hit       = lkValid && anyMatch && permOk;
  assign protFault = lkValid && anyMatch && !permOk;
  assign missFault = lkValid && !anyMatch;
  assign physAddr  = hit ? {frameQ[hitIdx], lkOff} : '0;

  // status bits: hit updates first, commands override
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= '0;
      touchedQ <= '0;
      dirtyQ   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (hit && (hitIdx == IDX_W'(i))) begin
          touchedQ[i] <= 1'b1;
          if (lkIsWrite) dirtyQ[i] <= 1'b1;
        end
        if (strb.clrTouched) touchedQ[i] <= 1'b0;
        if (strb.invAll || (strb.invPid && (pidQ[i] == cmdPid))) validQ[i] <= 1'b0;
        if (strb.fill && (fillIdx == IDX_W'(i))) begin
          validQ[i]   <= 1'b1;
          touchedQ[i] <= 1'b0;
          dirtyQ[i]   <= 1'b0;
        end
      end
    end
  end

  // mapping payload, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strb.fill && (fillIdx == IDX_W'(i))) begin
        vpnQ[i]   <= cmdVpn;
        pidQ[i]   <= cmdPid;
        frameQ[i] <= cmdFrame;
        rdQ[i]    <= cmdPermRd;
        wrQ[i]    <= cmdPermWr;
      end
    end
  end

  assign validVec    = validQ;
  assign touchedVec  = touchedQ;
  assign statValid   = validQ[statIdx];
  assign statTouched = touchedQ[statIdx];
  assign statDirty   = dirtyQ[statIdx];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, missFault, protFault})); // R4

  AST_TOUCH_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (hit && strb == '0) |=> touchedQ[$past(hitIdx)]); // R5

  AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hit && lkIsWrite && strb == '0) |=> dirtyQ[$past(hitIdx)]); // R5

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(validQ)); // R6

  AST_CLR_TOUCH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrTouched && !strb.fill) |=> (touchedQ == '0)); // R9

endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
  import pid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupIsWrite,
  input  logic [VA_W-1:0]    lookupVaddr,
  input  logic [PID_W-1:0]   curPid,
  output logic               hit,
  output logic               missFault,
  output logic               protFault,
  output logic [PA_W-1:0]    physAddr,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic               cmdPriv,
  input  logic [VPN_W-1:0]   cmdVpn,
  input  logic [PID_W-1:0]   cmdPid,
  input  logic [FRAME_W-1:0] cmdFrame,
  input  logic               cmdPermRd,
  input  logic               cmdPermWr,
  output logic               privFault,
  output logic [IDX_W-1:0]   victimIdx,
  input  logic [IDX_W-1:0]   statIdx,
  output logic               statValid,
  output logic               statTouched,
  output logic               statDirty
);

  strobe_t            strb;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] validVec, touchedVec;

  pid_tlb_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPriv(cmdPriv),
    .validVec(validVec), .touchedVec(touchedVec),
    .strb(strb), .fillIdx(fillIdx), .victimIdx(victimIdx),
    .privFault(privFault)
  );

  pid_tlb_dpath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .FRAME_W(FRAME_W),
    .PID_W(PID_W), .OFF_W(OFF_W)
  ) uDpath (
    .clk(clk), .rstN(rstN),
    .lkValid(lookupValid), .lkIsWrite(lookupIsWrite),
    .lkVpn(lookupVaddr[VA_W-1:OFF_W]), .lkOff(lookupVaddr[OFF_W-1:0]),
    .lkPid(curPid),
    .hit(hit), .missFault(missFault), .protFault(protFault),
    .physAddr(physAddr),
    .strb(strb), .fillIdx(fillIdx),
    .cmdVpn(cmdVpn), .cmdPid(cmdPid), .cmdFrame(cmdFrame),
    .cmdPermRd(cmdPermRd), .cmdPermWr(cmdPermWr),
    .validVec(validVec), .touchedVec(touchedVec),
    .statIdx(statIdx), .statValid(statValid),
    .statTouched(statTouched), .statDirty(statDirty)
  );

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (physAddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0])); // R2

endmodule

// File: tb/sim_pid_tlb.sv
module sim_pid_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid, lookupIsWrite;
  logic [31:0] lookupVaddr;
  logic [7:0]  curPid;
  logic        hit, missFault, protFault;
  logic [31:0] physAddr;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic        cmdPriv;
  logic [19:0] cmdVpn;
  logic [7:0]  cmdPid;
  logic [19:0] cmdFrame;
  logic        cmdPermRd, cmdPermWr;
  logic        privFault;
  logic [3:0]  victimIdx;
  logic [3:0]  statIdx;
  logic        statValid, statTouched, statDirty;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pid_tlb u0 (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupIsWrite(lookupIsWrite),
    .lookupVaddr(lookupVaddr), .curPid(curPid),
    .hit(hit), .missFault(missFault), .protFault(protFault), .physAddr(physAddr),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPriv(cmdPriv),
    .cmdVpn(cmdVpn), .cmdPid(cmdPid), .cmdFrame(cmdFrame),
    .cmdPermRd(cmdPermRd), .cmdPermWr(cmdPermWr),
    .privFault(privFault), .victimIdx(victimIdx),
    .statIdx(statIdx), .statValid(statValid),
    .statTouched(statTouched), .statDirty(statDirty)
  );

  // kind: 0 lookup, else command code; perm = {wr, rd}
  typedef struct packed {
    logic [2:0]  kind;
    logic        priv;
    logic        wr;
    logic [19:0] vpn;
    logic [11:0] off;
    logic [7:0]  pid;
    logic [19:0] frame;
    logic [1:0]  perm;
    logic        eHit;
    logic        eMiss;
    logic        eProt;
    logic        ePriv;
    logic [19:0] eFrame;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 20'h12345, 12'h0AB, 8'd1, 20'h0,     2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0},     // R1 empty
    '{3'd1, 1'b1, 1'b0, 20'h12345, 12'h000, 8'd1, 20'hABCDE, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // fill e0
    '{3'd0, 1'b0, 1'b0, 20'h12345, 12'h7F3, 8'd1, 20'h0,     2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 20'hABCDE}, // R2
    '{3'd0, 1'b0, 1'b0, 20'h12345, 12'h7F3, 8'd2, 20'h0,     2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0},     // R3 other pid
    '{3'd1, 1'b1, 1'b0, 20'h00042, 12'h000, 8'd2, 20'h00777, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // fill e1 read-only
    '{3'd0, 1'b0, 1'b1, 20'h00042, 12'h010, 8'd2, 20'h0,     2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // R4 write denied
    '{3'd0, 1'b0, 1'b0, 20'h00042, 12'hFFF, 8'd2, 20'h0,     2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00777},
    '{3'd1, 1'b0, 1'b0, 20'h99999, 12'h000, 8'd1, 20'h11111, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 20'h0},     // R6 user fill
    '{3'd0, 1'b0, 1'b0, 20'h99999, 12'h000, 8'd1, 20'h0,     2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0},     // R6 no effect
    '{3'd1, 1'b1, 1'b0, 20'h00500, 12'h000, 8'd3, 20'h55555, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // fill e2 write-only
    '{3'd0, 1'b0, 1'b0, 20'h00500, 12'h004, 8'd3, 20'h0,     2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // R4 read denied
    '{3'd0, 1'b0, 1'b1, 20'h00500, 12'h004, 8'd3, 20'h0,     2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 20'h55555},
    '{3'd3, 1'b1, 1'b0, 20'h00000, 12'h000, 8'd2, 20'h0,     2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // R8 inv pid 2
    '{3'd0, 1'b0, 1'b0, 20'h00042, 12'h000, 8'd2, 20'h0,     2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0},     // R8 gone
    '{3'd0, 1'b0, 1'b0, 20'h12345, 12'h001, 8'd1, 20'h0,     2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 20'hABCDE}, // R8 others kept
    '{3'd2, 1'b0, 1'b0, 20'h00000, 12'h000, 8'd0, 20'h0,     2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 20'h0},     // R6 user inv all
    '{3'd0, 1'b0, 1'b0, 20'h12345, 12'h002, 8'd1, 20'h0,     2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 20'hABCDE}  // R6 kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    lookupValid = 0; lookupIsWrite = 0; lookupVaddr = '0; curPid = '0;
    cmdValid = 0; cmdOp = 3'd0; cmdPriv = 0; cmdVpn = '0; cmdPid = '0;
    cmdFrame = '0; cmdPermRd = 0; cmdPermWr = 0;
  endtask

  task automatic doLookup(input logic wr, input logic [19:0] vpn, input logic [11:0] off,
                          input logic [7:0] pid);
    @(negedge clk);
    idle();
    lookupValid = 1; lookupIsWrite = wr; lookupVaddr = {vpn, off}; curPid = pid;
    #2;
  endtask

  task automatic doCmd(input logic [2:0] op, input logic priv, input logic [19:0] vpn,
                       input logic [7:0] pid, input logic [19:0] frame, input logic [1:0] perm);
    @(negedge clk);
    idle();
    cmdValid = 1; cmdOp = op; cmdPriv = priv; cmdVpn = vpn; cmdPid = pid;
    cmdFrame = frame; cmdPermRd = perm[0]; cmdPermWr = perm[1];
    #2;
  endtask

  task automatic settle();
    @(negedge clk);
    idle();
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finishRun();
      end
    end
  end

  initial begin
    idle();
    statIdx = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    settle();

    // R11: reset state
    for (int k = 0; k < 16; k++) begin
      statIdx = 4'(k); #1;
      check("R11 valid", {31'd0, statValid}, 32'd0);
      check("R11 touched/dirty", {30'd0, statTouched, statDirty}, 32'd0);
    end
    check("R11 victim", {28'd0, victimIdx}, 32'd0);
    check("R1 idle quiet", {29'd0, hit, missFault, protFault}, 32'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].kind == 3'd0) begin
        doLookup(VECS[v].wr, VECS[v].vpn, VECS[v].off, VECS[v].pid);
        check(VECS[v].eMiss ? "R1/R3 outcome" : (VECS[v].eProt ? "R4 outcome" : "R2 outcome"),
              {29'd0, hit, missFault, protFault},
              {29'd0, VECS[v].eHit, VECS[v].eMiss, VECS[v].eProt});
        check("R2 physAddr", physAddr,
              VECS[v].eHit ? {VECS[v].eFrame, VECS[v].off} : 32'd0);
      end else begin
        doCmd(VECS[v].kind, VECS[v].priv, VECS[v].vpn, VECS[v].pid, VECS[v].frame, VECS[v].perm);
        check("R6 privFault", {31'd0, privFault}, {31'd0, VECS[v].ePriv});
      end
    end
    settle();

    // R10/R5 status readback after table
    statIdx = 4'd0; #1;
    check("R5 e0 touched, clean", {29'd0, statValid, statTouched, statDirty}, 32'b110);
    statIdx = 4'd1; #1;
    check("R8 e1 invalid", {31'd0, statValid}, 32'd0);
    statIdx = 4'd2; #1;
    check("R5 e2 touched, dirty", {29'd0, statValid, statTouched, statDirty}, 32'b111);
    check("R7 victim lowest invalid", {28'd0, victimIdx}, 32'd1);

    // reserved op ignored
    doCmd(3'd6, 1'b0, 20'h0, 8'd0, 20'h0, 2'b00);
    check("R6 reserved op", {31'd0, privFault}, 32'd0);

    // R8: invalidate all
    doCmd(3'd2, 1'b1, 20'h0, 8'd0, 20'h0, 2'b00);
    settle();
    for (int k = 0; k < 3; k++) begin
      statIdx = 4'(k); #1;
      check("R8 inv all", {31'd0, statValid}, 32'd0);
    end

    // R7: fill all entries in order
    for (int k = 0; k < 16; k++) begin
      settle();
      check("R7 victim order", {28'd0, victimIdx}, k);
      doCmd(3'd1, 1'b1, 20'h00100 + 20'(k), 8'd5, 20'h30000 + 20'(k), 2'b11);
    end
    settle();
    check("R7 none touched -> lowest cold", {28'd0, victimIdx}, 32'd0);
    statIdx = 4'd9; #1;
    check("R7 fill clears status", {29'd0, statValid, statTouched, statDirty}, 32'b100);

    doLookup(1'b0, 20'h00100, 12'h123, 8'd5);
    check("R2 full array hit", physAddr, {20'h30000, 12'h123});
    doLookup(1'b0, 20'h00101, 12'h000, 8'd5);
    settle();
    check("R7 lowest untouched", {28'd0, victimIdx}, 32'd2);

    for (int k = 2; k < 16; k++) begin
      doLookup(1'b1, 20'h00100 + 20'(k), 12'h0, 8'd5);
      check("R2 frame", physAddr, {20'h30000 + 20'(k), 12'h0});
    end
    settle();
    check("R7 all touched -> 0", {28'd0, victimIdx}, 32'd0);

    // user clear-touched refused, state kept
    doCmd(3'd4, 1'b0, 20'h0, 8'd0, 20'h0, 2'b00);
    check("R6 user clr", {31'd0, privFault}, 32'd1);
    settle();
    statIdx = 4'd5; #1;
    check("R6 touched kept", {31'd0, statTouched}, 32'd1);

    // R9: clear touched competing with a hit in the same cycle
    @(negedge clk);
    idle();
    cmdValid = 1; cmdOp = 3'd4; cmdPriv = 1;
    lookupValid = 1; lookupVaddr = {20'h00107, 12'h0}; curPid = 8'd5;
    #2;
    check("R9 hit during clear", {31'd0, hit}, 32'd1);
    settle();
    for (int k = 0; k < 16; k++) begin
      statIdx = 4'(k); #1;
      check("R9 touched cleared", {31'd0, statTouched}, 32'd0);
    end
    statIdx = 4'd3; #1;
    check("R10 dirty kept", {29'd0, statValid, statTouched, statDirty}, 32'b101);
    check("R9 victim after clear", {28'd0, victimIdx}, 32'd0);

    finishRun();
  end

endmodule